// File: doc/BRIEF.md
# Prefixed Arithmetic Opcode Decoder with Cycle Timing

This block watches an instruction byte stream for the 16-bit and memory-decrement arithmetic subset of an 8-bit CPU. It accepts one byte per cycle in which the byte strobe is high. It follows the index-register prefix and the extended-page prefix across bytes. For an indexed memory decrement it also takes the trailing displacement byte. When the last byte of a supported instruction arrives, it reports the following on a one-cycle valid pulse:

- the operation kind;
- the destination register;
- the source register;
- the sign-extended displacement;
- the machine-cycle count and the clock-state (T-state) count.

A byte that cannot start or continue a supported instruction gives a one-cycle illegal pulse instead. The decoder then goes back to its start state.

The block is meant to sit beside a fetch unit, which gives it a timing and operand-selection view of each instruction. It does not execute anything and does not read memory.

Top module: `arith_opdec`

## Requirements
- R1: After reset, `outValid` and `outIllegal` are 0 and the decoder is in its start state, so the next byte is decoded as the first byte of an instruction.
- R2: The single byte 0x35 reports a memory decrement: op=1, dst=HL(2), src=HL(2), disp=0, 3 M-cycles and 11 T-states. `outValid` rises in the cycle after the byte is accepted.
- R3: A prefix byte of the form 11x11101 selects an index register: x=0 gives IX (code 4) and x=1 gives IY (code 5). Prefix, then 0x35, then a byte d reports op=1 with dst=src=the index register, disp=d sign-extended to 16 bits, 6 M-cycles and 23 T-states. The report comes after d.
- R4: A byte 00pp1001 with no prefix reports op=2, dst=HL, src=pair pp, 3 M-cycles and 11 T-states. The pair codes are BC=0, DE=1, HL=2, SP=3.
- R5: An index prefix followed by 00pp1001 reports op=2, dst=the index register, 4 M-cycles and 15 T-states. src is pair pp, except that pp=10 names the index register itself.
- R6: Byte 0xED followed by 01pp1010 reports op=3 (add with carry). Byte 0xED followed by 01pp0010 reports op=4 (subtract with borrow). Both give dst=HL, src=pair pp, 4 M-cycles and 15 T-states.
- R7: A byte 00pp0011 with no prefix reports op=5 (increment), dst=src=pair pp, 1 M-cycle and 6 T-states.
- R8: An index prefix followed by 0x23 reports op=5 with dst=src=the index register, 2 M-cycles and 10 T-states.
- R9: A byte that is not supported in the current state gives `outIllegal`=1 for one cycle, in the cycle after that byte, with `outValid`=0, and the decoder returns to its start state. This covers an unknown first byte, any byte after a prefix other than those in R3, R5 and R8, and any byte after 0xED other than those in R6.
- R10: Cycles with `byteValid`=0 change neither the outputs nor the decoder state, whatever `byteIn` holds.
- R11: Prefix bytes and the 0x35 after an index prefix produce no pulse. Each complete instruction gives exactly one single-cycle `outValid` pulse, including back-to-back instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Strobe: `byteIn` holds an instruction byte this cycle |
| byteIn | input | 8 | Instruction byte |
| outValid | output | 1 | One-cycle pulse: a complete instruction was decoded |
| outIllegal | output | 1 | One-cycle pulse: an unsupported byte was seen |
| outOp | output | 3 | Operation: 1 memory decrement, 2 add, 3 add with carry, 4 subtract with borrow, 5 increment |
| outDst | output | 3 | Destination register: 0 BC, 1 DE, 2 HL, 3 SP, 4 IX, 5 IY |
| outSrc | output | 3 | Source register, same coding as outDst |
| outDisp | output | 16 | Sign-extended displacement; 0 for non-indexed operations |
| outMCycles | output | 3 | Machine-cycle count |
| outTStates | output | 5 | T-state count |

## Verification
The patterns cover:

- All four pair codes, both with and without an index prefix. This separates pair code 10 as HL from pair code 10 as the selected index register.
- Both prefix variants. This shows that prefix bit 5 alone chooses IX or IY.
- Negative and positive displacements. These confirm the sign extension.
- Illegal bytes in every decoder state, each followed by a valid instruction. This shows the return to the start state.
- Idle strobe gaps inserted inside a multi-byte instruction. These show that partial progress is held.
- Back-to-back single-byte instructions. These separate one pulse per instruction from a stretched pulse.

// File: rtl/arith_opdec_pkg.sv
package arith_opdec_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_DECM = 3'd1,
    OP_ADD  = 3'd2,
    OP_ADC  = 3'd3,
    OP_SBC  = 3'd4,
    OP_INC  = 3'd5
  } opKind_t;

  typedef enum logic [2:0] {
    RG_BC = 3'd0,
    RG_DE = 3'd1,
    RG_HL = 3'd2,
    RG_SP = 3'd3,
    RG_IX = 3'd4,
    RG_IY = 3'd5
  } regSel_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INDEX,
    ST_EXT,
    ST_DISP
  } decState_t;

  // strobes from control to datapath, valid in the cycle of the accepted byte
  typedef struct packed {
    logic    emit;
    logic    illegal;
    logic    useIdx;
    logic    idxIsY;
    logic    takeDisp;
    opKind_t op;
  } ctrlStrobe_t;

endpackage

// File: rtl/arith_opdec_ctrl.sv
module arith_opdec_ctrl
  import arith_opdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  output ctrlStrobe_t strobe
);

  localparam logic [7:0] BYTE_DEC_MEM = 8'h35;
  localparam logic [7:0] BYTE_EXT     = 8'hED;
  localparam logic [7:0] BYTE_INC_IDX = 8'h23;

  decState_t state, nextState;
  logic      idxIsY, nextIdxIsY;

  logic isIdxPrefix, isAdd16, isInc16, isAdcExt, isSbcExt;

  always_comb begin
    isIdxPrefix = (byteIn[7:6] == 2'b11) && (byteIn[4:0] == 5'b11101);
    isAdd16     = (byteIn[7:6] == 2'b00) && (byteIn[3:0] == 4'b1001);
    isInc16     = (byteIn[7:6] == 2'b00) && (byteIn[3:0] == 4'b0011);
    isAdcExt    = (byteIn[7:6] == 2'b01) && (byteIn[3:0] == 4'b1010);
    isSbcExt    = (byteIn[7:6] == 2'b01) && (byteIn[3:0] == 4'b0010);
  end

  always_comb begin
    strobe        = '0;
    strobe.op     = OP_NONE;
    strobe.idxIsY = idxIsY;
    nextState     = state;
    nextIdxIsY    = idxIsY;
    if (byteValid) begin
      unique case (state)
        ST_IDLE: begin
          if (byteIn == BYTE_DEC_MEM) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_DECM;
          end else if (isAdd16) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_ADD;
          end else if (isInc16) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_INC;
          end else if (isIdxPrefix) begin
            nextState  = ST_INDEX;
            nextIdxIsY = byteIn[5];
          end else if (byteIn == BYTE_EXT) begin
            nextState = ST_EXT;
          end else begin
            strobe.illegal = 1'b1;
          end
        end
        ST_INDEX: begin
          nextState     = ST_IDLE;
          strobe.useIdx = 1'b1;
          if (byteIn == BYTE_DEC_MEM) begin
            nextState = ST_DISP;
          end else if (isAdd16) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_ADD;
          end else if (byteIn == BYTE_INC_IDX) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_INC;
          end else begin
            strobe.illegal = 1'b1;
          end
        end
        ST_EXT: begin
          nextState = ST_IDLE;
          if (isAdcExt) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_ADC;
          end else if (isSbcExt) begin
            strobe.emit = 1'b1;
            strobe.op   = OP_SBC;
          end else begin
            strobe.illegal = 1'b1;
          end
        end
        ST_DISP: begin
          nextState       = ST_IDLE;
          strobe.emit     = 1'b1;
          strobe.useIdx   = 1'b1;
          strobe.takeDisp = 1'b1;
          strobe.op       = OP_DECM;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idxIsY <= 1'b0;
    end else begin
      state  <= nextState;
      idxIsY <= nextIdxIsY;
    end
  end

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(state) && $stable(idxIsY)); // R10
  AST_DISP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISP) && byteValid |=> state == ST_IDLE); // R3
  AST_ILLEGAL_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |=> state == ST_IDLE); // R9
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.emit && strobe.illegal)); // R9

endmodule

// File: rtl/arith_opdec_dpath.sv
module arith_opdec_dpath
  import arith_opdec_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int MC_W   = 3,
  parameter int TS_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        byteIn,
  output logic              outValid,
  output logic              outIllegal,
  output logic [2:0]        outOp,
  output logic [2:0]        outDst,
  output logic [2:0]        outSrc,
  output logic [DISP_W-1:0] outDisp,
  output logic [MC_W-1:0]   outMCycles,
  output logic [TS_W-1:0]   outTStates
);

  localparam int EXT_W = DISP_W - 8;

  // machine-cycle and T-state figures per instruction form
  localparam logic [MC_W-1:0] MC_DEC_HL  = MC_W'(3);
  localparam logic [TS_W-1:0] TS_DEC_HL  = TS_W'(11);
  localparam logic [MC_W-1:0] MC_DEC_IDX = MC_W'(6);
  localparam logic [TS_W-1:0] TS_DEC_IDX = TS_W'(23);
  localparam logic [MC_W-1:0] MC_ADD_HL  = MC_W'(3);
  localparam logic [TS_W-1:0] TS_ADD_HL  = TS_W'(11);
  localparam logic [MC_W-1:0] MC_LONG16  = MC_W'(4);
  localparam logic [TS_W-1:0] TS_LONG16  = TS_W'(15);
  localparam logic [MC_W-1:0] MC_INC_RR  = MC_W'(1);
  localparam logic [TS_W-1:0] TS_INC_RR  = TS_W'(6);
  localparam logic [MC_W-1:0] MC_INC_IDX = MC_W'(2);
  localparam logic [TS_W-1:0] TS_INC_IDX = TS_W'(10);

  regSel_t             pairSel, idxSel, pairOrIdx, dstNext, srcNext;
  logic [MC_W-1:0]     mcNext;
  logic [TS_W-1:0]     tsNext;
  logic [DISP_W-1:0]   dispNext;

  always_comb begin
    pairSel   = regSel_t'({1'b0, byteIn[5:4]});
    idxSel    = strobe.idxIsY ? RG_IY : RG_IX;
    pairOrIdx = (strobe.useIdx && pairSel == RG_HL) ? idxSel : pairSel;
  end

  generate
    if (EXT_W > 0) begin : gSignExt
      always_comb dispNext = strobe.takeDisp ? {{EXT_W{byteIn[7]}}, byteIn} : '0;
    end else begin : gNoExt
      always_comb dispNext = strobe.takeDisp ? byteIn[DISP_W-1:0] : '0;
    end
  endgenerate

  always_comb begin
    dstNext = RG_HL;
    srcNext = RG_HL;
    mcNext  = '0;
    tsNext  = '0;
    unique case (strobe.op)
      OP_DECM: begin
        dstNext = strobe.useIdx ? idxSel : RG_HL;
        srcNext = dstNext;
        mcNext  = strobe.useIdx ? MC_DEC_IDX : MC_DEC_HL;
        tsNext  = strobe.useIdx ? TS_DEC_IDX : TS_DEC_HL;
      end
      OP_ADD: begin
        dstNext = strobe.useIdx ? idxSel : RG_HL;
        srcNext = pairOrIdx;
        mcNext  = strobe.useIdx ? MC_LONG16 : MC_ADD_HL;
        tsNext  = strobe.useIdx ? TS_LONG16 : TS_ADD_HL;
      end
      OP_ADC, OP_SBC: begin
        dstNext = RG_HL;
        srcNext = pairSel;
        mcNext  = MC_LONG16;
        tsNext  = TS_LONG16;
      end
      OP_INC: begin
        dstNext = strobe.useIdx ? idxSel : pairSel;
        srcNext = dstNext;
        mcNext  = strobe.useIdx ? MC_INC_IDX : MC_INC_RR;
        tsNext  = strobe.useIdx ? TS_INC_IDX : TS_INC_RR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outOp      <= OP_NONE;
      outDst     <= RG_BC;
      outSrc     <= RG_BC;
      outDisp    <= '0;
      outMCycles <= '0;
      outTStates <= '0;
    end else begin
      outValid   <= strobe.emit;
      outIllegal <= strobe.illegal;
      if (strobe.emit) begin
        outOp      <= strobe.op;
        outDst     <= dstNext;
        outSrc     <= srcNext;
        outDisp    <= dispNext;
        outMCycles <= mcNext;
        outTStates <= tsNext;
      end
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outIllegal)); // R9
  AST_TIMING_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMCycles != '0) && (int'(outTStates) >= 3 * int'(outMCycles))); // R2
  AST_DISP_ONLY_DECM: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outOp != OP_DECM) |-> outDisp == '0); // R4
  AST_ILLEGAL_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> $stable(outOp) && $stable(outTStates)); // R9

endmodule

// File: rtl/arith_opdec.sv
module arith_opdec
  import arith_opdec_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int MC_W   = 3,
  parameter int TS_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteIn,
  output logic              outValid,
  output logic              outIllegal,
  output logic [2:0]        outOp,
  output logic [2:0]        outDst,
  output logic [2:0]        outSrc,
  output logic [DISP_W-1:0] outDisp,
  output logic [MC_W-1:0]   outMCycles,
  output logic [TS_W-1:0]   outTStates
);

  ctrlStrobe_t strobe;

  arith_opdec_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .strobe    (strobe)
  );

  arith_opdec_dpath #(
    .DISP_W (DISP_W),
    .MC_W   (MC_W),
    .TS_W   (TS_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .byteIn     (byteIn),
    .outValid   (outValid),
    .outIllegal (outIllegal),
    .outOp      (outOp),
    .outDst     (outDst),
    .outSrc     (outSrc),
    .outDisp    (outDisp),
    .outMCycles (outMCycles),
    .outTStates (outTStates)
  );

endmodule

// File: tb/arith_opdec_tb_top.sv
module arith_opdec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = 8'h00;
  logic        outValid, outIllegal;
  logic [2:0]  outOp, outDst, outSrc;
  logic [15:0] outDisp;
  logic [2:0]  outMCycles;
  logic [4:0]  outTStates;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  arith_opdec dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .byteIn     (byteIn),
    .outValid   (outValid),
    .outIllegal (outIllegal),
    .outOp      (outOp),
    .outDst     (outDst),
    .outSrc     (outSrc),
    .outDisp    (outDisp),
    .outMCycles (outMCycles),
    .outTStates (outTStates)
  );

  // drive at a falling edge, let one rising edge take it, stop at the next falling edge
  task automatic putByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteIn    = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic idleCycles(input int n, input logic [7:0] junk);
    byteIn = junk;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectDecode(input string req, input int op, input int dst, input int src,
                              input logic [15:0] disp, input int mc, input int ts);
    checks++;
    if (!(outValid === 1'b1 && outIllegal === 1'b0 && outOp == op && outDst == dst &&
          outSrc == src && outDisp == disp && outMCycles == mc && outTStates == ts)) begin
      errors++;
      $display("FAIL %s: got v=%0b ill=%0b op=%0d dst=%0d src=%0d disp=%h mc=%0d ts=%0d, expected v=1 ill=0 op=%0d dst=%0d src=%0d disp=%h mc=%0d ts=%0d",
               req, outValid, outIllegal, outOp, outDst, outSrc, outDisp, outMCycles, outTStates,
               op, dst, src, disp, mc, ts);
    end
  endtask

  task automatic expectQuiet(input string req);
    checks++;
    if (!(outValid === 1'b0 && outIllegal === 1'b0)) begin
      errors++;
      $display("FAIL %s: got v=%0b ill=%0b, expected v=0 ill=0", req, outValid, outIllegal);
    end
  endtask

  task automatic expectIllegal(input string req);
    checks++;
    if (!(outValid === 1'b0 && outIllegal === 1'b1)) begin
      errors++;
      $display("FAIL %s: got v=%0b ill=%0b, expected v=0 ill=1", req, outValid, outIllegal);
    end
  endtask

  task automatic tReset();
    rstN = 1'b0;
    idleCycles(3, 8'h35);
    rstN = 1'b1;
    expectQuiet("R1 reset outputs");
    putByte(8'h35);
    expectDecode("R1 first byte after reset", 1, 2, 2, 16'h0000, 3, 11);
  endtask

  task automatic tDecHl();
    putByte(8'h35);
    expectDecode("R2 decrement via HL", 1, 2, 2, 16'h0000, 3, 11);
    idleCycles(1, 8'h00);
    expectQuiet("R11 pulse lasts one cycle");
  endtask

  task automatic tDecIdx();
    putByte(8'hDD);
    expectQuiet("R11 no pulse after prefix");
    putByte(8'h35);
    expectQuiet("R11 no pulse before displacement");
    putByte(8'h80);
    expectDecode("R3 IX negative displacement", 1, 4, 4, 16'hFF80, 6, 23);
    putByte(8'hFD);
    putByte(8'h35);
    putByte(8'h05);
    expectDecode("R3 IY positive displacement", 1, 5, 5, 16'h0005, 6, 23);
  endtask

  task automatic tAddHl();
    for (int p = 0; p < 4; p++) begin
      putByte({2'b00, p[1:0], 4'b1001});
      expectDecode("R4 add to HL", 2, 2, p, 16'h0000, 3, 11);
    end
  endtask

  task automatic tAddIdx();
    for (int p = 0; p < 4; p++) begin
      putByte(8'hDD);
      putByte({2'b00, p[1:0], 4'b1001});
      expectDecode("R5 add to IX", 2, 4, (p == 2) ? 4 : p, 16'h0000, 4, 15);
    end
    putByte(8'hFD);
    putByte(8'h29);
    expectDecode("R5 add IY to itself", 2, 5, 5, 16'h0000, 4, 15);
    putByte(8'hFD);
    putByte(8'h39);
    expectDecode("R5 add SP to IY", 2, 5, 3, 16'h0000, 4, 15);
  endtask

  task automatic tAdcSbc();
    for (int p = 0; p < 4; p++) begin
      putByte(8'hED);
      expectQuiet("R11 no pulse after extended prefix");
      putByte({2'b01, p[1:0], 4'b1010});
      expectDecode("R6 add with carry", 3, 2, p, 16'h0000, 4, 15);
      putByte(8'hED);
      putByte({2'b01, p[1:0], 4'b0010});
      expectDecode("R6 subtract with borrow", 4, 2, p, 16'h0000, 4, 15);
    end
  endtask

  task automatic tIncRr();
    for (int p = 0; p < 4; p++) begin
      putByte({2'b00, p[1:0], 4'b0011});
      expectDecode("R7 increment pair", 5, p, p, 16'h0000, 1, 6);
    end
  endtask

  task automatic tIncIdx();
    putByte(8'hDD);
    putByte(8'h23);
    expectDecode("R8 increment IX", 5, 4, 4, 16'h0000, 2, 10);
    putByte(8'hFD);
    putByte(8'h23);
    expectDecode("R8 increment IY", 5, 5, 5, 16'h0000, 2, 10);
  endtask

  task automatic tIllegal();
    putByte(8'h00);
    expectIllegal("R9 unknown first byte");
    idleCycles(1, 8'h00);
    expectQuiet("R9 illegal pulse lasts one cycle");
    putByte(8'hDD);
    putByte(8'h13);
    expectIllegal("R9 pair increment after prefix");
    putByte(8'h23);
    expectDecode("R9 start state after illegal", 5, 2, 2, 16'h0000, 1, 6);
    putByte(8'hED);
    putByte(8'h35);
    expectIllegal("R9 unknown extended byte");
    putByte(8'h35);
    expectDecode("R9 plain decode after extended illegal", 1, 2, 2, 16'h0000, 3, 11);
    putByte(8'hFD);
    putByte(8'hDD);
    expectIllegal("R9 prefix after prefix");
    putByte(8'h09);
    expectDecode("R9 no prefix left over", 2, 2, 0, 16'h0000, 3, 11);
  endtask

  task automatic tIgnore();
    idleCycles(3, 8'h35);
    expectQuiet("R10 byte without strobe ignored");
    putByte(8'hFD);
    idleCycles(3, 8'h00);
    expectQuiet("R10 no illegal while strobe low");
    putByte(8'h35);
    idleCycles(2, 8'hDD);
    putByte(8'hFE);
    expectDecode("R10 gaps inside indexed decrement", 1, 5, 5, 16'hFFFE, 6, 23);
  endtask

  task automatic tBackToBack();
    putByte(8'h03);
    expectDecode("R11 first of back-to-back", 5, 0, 0, 16'h0000, 1, 6);
    putByte(8'h13);
    expectDecode("R11 second of back-to-back", 5, 1, 1, 16'h0000, 1, 6);
    idleCycles(1, 8'h00);
    expectQuiet("R11 quiet after back-to-back");
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tDecHl();
    tDecIdx();
    tAddHl();
    tAddIdx();
    tAdcSbc();
    tIncRr();
    tIncIdx();
    tIllegal();
    tIgnore();
    tBackToBack();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule